// File: doc/BRIEF.md
# PTP Event Timestamp Capture

This block records the value of a free-running time counter at the moment a precision-time-protocol event frame starts, on receive and on transmit, each in its own slot. The frame parser upstream provides a start-of-frame strobe and the header fields it has already decoded: ethertype, IP protocol, UDP source and destination ports, the PTP version and the PTP message type. For each direction, a classifier decides from these fields and a filter mode whether the frame qualifies. A qualifying frame copies the 64-bit time into the slot and raises a valid flag.

Each slot holds one stamp and then locks itself. While the valid flag is set, later frames in that direction leave the slot untouched. Software reads the stamp as a low word and then a high word. The read of the high word, signalled by a one-cycle strobe, clears the flag and opens the slot for the next frame. The transport checks (layer-2 ethertype, layer-4 UDP port and an optional source-port match) are shared by both directions. The enable bit, the filter mode and the version-1 message selector are set separately for each direction.

Top module: `ptp_evstamp`

## Requirements
- R1: After reset both valid flags are 0 and both stamp words are 0.
- R2: A start-of-frame strobe on a direction whose enable is 1, whose frame qualifies and whose valid flag is 0 sets the valid flag at the next clock edge. At that edge the stamp takes the time input present in the strobe cycle: the low word is bits 31:0 and the high word is bits 63:32.
- R3: While a valid flag is 1 and no high-word read is strobed, the flag stays 1 and both stamp words hold their value, whatever frames arrive.
- R4: A high-word read strobe while the valid flag is 1 clears the flag at the next edge. The stamp words keep their last value.
- R5: While a direction's enable is 0, no stamp is taken. A stamp that was already valid when the enable was cleared stays valid, unchanged, until it is read.
- R6: With the layer-2 check enabled, ethertype 0x88F7 counts as PTP transport. With that check disabled, the ethertype alone never qualifies a frame.
- R7: With the layer-4 check enabled, IP protocol 17 (UDP) with destination port 319 counts as PTP transport. When the source-port check is also enabled, the source port must be 319 as well.
- R8: Mode 0 (version-1 over UDP) stamps only frames with layer-4 transport, version 1, and a message type equal to the selector (0 selects Sync, 1 selects Delay_Req).
- R9: Mode 1 (version-2 events) stamps frames with either transport, version 2 and a message type from 0 to 3. Message types 4 to 15 are not stamped.
- R10: Mode 2 stamps every frame whatever its fields. Mode 3 stamps none.
- R11: The receive and transmit slots are independent. A capture or a read in one direction leaves the other direction's flag and stamp unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current time counter value |
| l2_chk_en | input | 1 | Accept ethertype 0x88F7 as PTP transport |
| l4_chk_en | input | 1 | Accept UDP to port 319 as PTP transport |
| sport_chk_en | input | 1 | Also require UDP source port 319 |
| rx_en | input | 1 | Receive capture enable |
| rx_mode | input | 2 | Receive filter mode (0 v1/UDP, 1 v2 events, 2 all, 3 none) |
| rx_v1_sel | input | 1 | Receive version-1 message selector (0 Sync, 1 Delay_Req) |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype | input | 16 | Receive frame ethertype |
| rx_ip_proto | input | 8 | Receive IP protocol number |
| rx_udp_dport | input | 16 | Receive UDP destination port |
| rx_udp_sport | input | 16 | Receive UDP source port |
| rx_ptp_ver | input | 4 | Receive PTP version |
| rx_ptp_msg | input | 4 | Receive PTP message type |
| rx_rd_hi | input | 1 | Receive high-word read strobe |
| tx_en | input | 1 | Transmit capture enable |
| tx_mode | input | 2 | Transmit filter mode |
| tx_v1_sel | input | 1 | Transmit version-1 message selector |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_ethertype | input | 16 | Transmit frame ethertype |
| tx_ip_proto | input | 8 | Transmit IP protocol number |
| tx_udp_dport | input | 16 | Transmit UDP destination port |
| tx_udp_sport | input | 16 | Transmit UDP source port |
| tx_ptp_ver | input | 4 | Transmit PTP version |
| tx_ptp_msg | input | 4 | Transmit PTP message type |
| tx_rd_hi | input | 1 | Transmit high-word read strobe |
| rx_valid | output | 1 | Receive stamp held |
| rx_stamp_lo | output | 32 | Receive stamp bits 31:0 |
| rx_stamp_hi | output | 32 | Receive stamp bits 63:32 |
| tx_valid | output | 1 | Transmit stamp held |
| tx_stamp_lo | output | 32 | Transmit stamp bits 31:0 |
| tx_stamp_hi | output | 32 | Transmit stamp bits 63:32 |

## Verification
The capture properties assume that header fields and the time input are steady and meaningful in the cycle the start-of-frame strobe is high, and that the strobe and the read strobe last one cycle each. The stimulus drives every field and the time value together with the strobe on the falling edge and drops the strobe one cycle later. It changes configuration only between frames. Each frame carries a distinct time value, so a stale or late capture shows up as a wrong word.

// File: rtl/ptp_evstamp_pkg.sv
package ptp_evstamp_pkg;

   typedef enum logic [1:0] {
      FM_V1_UDP   = 2'd0,
      FM_V2_EVENT = 2'd1,
      FM_ALL      = 2'd2,
      FM_NONE     = 2'd3
   } filt_mode_e;

   typedef struct packed {
      logic [15:0] ethertype;
      logic [7:0]  ip_proto;
      logic [15:0] dport;
      logic [15:0] sport;
      logic [3:0]  ver;
      logic [3:0]  msg;
   } frame_hdr_t;

   typedef struct packed {
      logic       l2_en;
      logic       l4_en;
      logic       sport_en;
   } xport_cfg_t;

   localparam logic [7:0] IPPROTO_UDP_C = 8'd17;

endpackage

// File: rtl/ptp_evstamp_classify.sv
module ptp_evstamp_classify
   import ptp_evstamp_pkg::*;
#(
   parameter logic [15:0] PTP_ETYPE  = 16'h88F7,
   parameter logic [15:0] EVENT_PORT = 16'd319,
   parameter int          EVENT_MSGS = 4
) (
   input  frame_hdr_t hdr,
   input  xport_cfg_t xcfg,
   input  filt_mode_e mode,
   input  logic       v1_sel,
   output logic       hit
);

   localparam logic [3:0] MSG_LIMIT = 4'(EVENT_MSGS);

   if (EVENT_MSGS < 1 || EVENT_MSGS > 15) begin : g_bad_msgs
      $error("EVENT_MSGS must lie in 1..15");
   end

   logic l2_ok;
   logic l4_ok;
   logic sport_ok;

   always_comb begin
      l2_ok    = xcfg.l2_en && (hdr.ethertype == PTP_ETYPE);
      sport_ok = !xcfg.sport_en || (hdr.sport == EVENT_PORT);
      l4_ok    = xcfg.l4_en && (hdr.ip_proto == IPPROTO_UDP_C) &&
                 (hdr.dport == EVENT_PORT) && sport_ok;
   end

   always_comb begin
      unique case (mode)
         FM_V1_UDP:   hit = l4_ok && (hdr.ver == 4'd1) &&
                            (hdr.msg == {3'b000, v1_sel});
         FM_V2_EVENT: hit = (l2_ok || l4_ok) && (hdr.ver == 4'd2) &&
                            (hdr.msg < MSG_LIMIT);
         FM_ALL:      hit = 1'b1;
         default:     hit = 1'b0;
      endcase
   end

   // R10: the "none" mode never qualifies a frame
   always_comb begin
      p_none_mode_r10: assert (!(mode == FM_NONE && hit));
   end

   // R8: version-1 mode only ever accepts a UDP-carried version-1 frame
   always_comb begin
      p_v1_fields_r8: assert (!(mode == FM_V1_UDP && hit) ||
                              (hdr.ver == 4'd1 && hdr.ip_proto == IPPROTO_UDP_C));
   end

endmodule

// File: rtl/ptp_evstamp_slot.sv
module ptp_evstamp_slot #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              sof,
   input  logic              hit,
   input  logic              rd_hi,
   input  logic [TIME_W-1:0] now,
   output logic              valid,
   output logic [TIME_W-1:0] stamp
);

   logic take;
   assign take = sof && arm && hit && !valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         stamp <= '0;
      end else if (take) begin
         valid <= 1'b1;
         stamp <= now;
      end else if (rd_hi) begin
         valid <= 1'b0;
      end
   end

   // R2: a qualifying frame on an open slot is captured with its own time
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sof && arm && hit && !valid) |=> (valid && stamp == $past(now)));

   // R3: the slot stays locked and frozen until the high word is read
   p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !rd_hi) |=> (valid && $stable(stamp)));

   // R4: reading the high word releases the slot
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && rd_hi) |=> (!valid && $stable(stamp)));

   // R5: a disabled empty slot stays empty
   p_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !arm) |=> !valid);

endmodule

// File: rtl/ptp_evstamp.sv
module ptp_evstamp
   import ptp_evstamp_pkg::*;
#(
   parameter int          TIME_W     = 64,
   parameter logic [15:0] PTP_ETYPE  = 16'h88F7,
   parameter logic [15:0] EVENT_PORT = 16'd319,
   parameter int          EVENT_MSGS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TIME_W-1:0]   time_now,
   input  logic                l2_chk_en,
   input  logic                l4_chk_en,
   input  logic                sport_chk_en,
   input  logic                rx_en,
   input  logic [1:0]          rx_mode,
   input  logic                rx_v1_sel,
   input  logic                rx_sof,
   input  logic [15:0]         rx_ethertype,
   input  logic [7:0]          rx_ip_proto,
   input  logic [15:0]         rx_udp_dport,
   input  logic [15:0]         rx_udp_sport,
   input  logic [3:0]          rx_ptp_ver,
   input  logic [3:0]          rx_ptp_msg,
   input  logic                rx_rd_hi,
   input  logic                tx_en,
   input  logic [1:0]          tx_mode,
   input  logic                tx_v1_sel,
   input  logic                tx_sof,
   input  logic [15:0]         tx_ethertype,
   input  logic [7:0]          tx_ip_proto,
   input  logic [15:0]         tx_udp_dport,
   input  logic [15:0]         tx_udp_sport,
   input  logic [3:0]          tx_ptp_ver,
   input  logic [3:0]          tx_ptp_msg,
   input  logic                tx_rd_hi,
   output logic                rx_valid,
   output logic [TIME_W/2-1:0] rx_stamp_lo,
   output logic [TIME_W/2-1:0] rx_stamp_hi,
   output logic                tx_valid,
   output logic [TIME_W/2-1:0] tx_stamp_lo,
   output logic [TIME_W/2-1:0] tx_stamp_hi
);

   localparam int WORD_W = TIME_W / 2;
   localparam int LANES  = 2;
   localparam int RX     = 0;
   localparam int TX     = 1;

   if (TIME_W % 2 != 0 || TIME_W < 2) begin : g_bad_width
      $error("TIME_W must be even and at least 2");
   end

   xport_cfg_t  xcfg;
   frame_hdr_t  hdr   [LANES];
   filt_mode_e  mode  [LANES];
   logic        v1sel [LANES];
   logic        arm   [LANES];
   logic        sof   [LANES];
   logic        rd    [LANES];
   logic        hit   [LANES];
   logic        vld   [LANES];
   logic [TIME_W-1:0] stamp [LANES];

   assign xcfg = '{l2_en: l2_chk_en, l4_en: l4_chk_en, sport_en: sport_chk_en};

   assign hdr[RX] = '{ethertype: rx_ethertype, ip_proto: rx_ip_proto,
                      dport: rx_udp_dport, sport: rx_udp_sport,
                      ver: rx_ptp_ver, msg: rx_ptp_msg};
   assign hdr[TX] = '{ethertype: tx_ethertype, ip_proto: tx_ip_proto,
                      dport: tx_udp_dport, sport: tx_udp_sport,
                      ver: tx_ptp_ver, msg: tx_ptp_msg};

   assign mode[RX]  = filt_mode_e'(rx_mode);
   assign mode[TX]  = filt_mode_e'(tx_mode);
   assign v1sel[RX] = rx_v1_sel;
   assign v1sel[TX] = tx_v1_sel;
   assign arm[RX]   = rx_en;
   assign arm[TX]   = tx_en;
   assign sof[RX]   = rx_sof;
   assign sof[TX]   = tx_sof;
   assign rd[RX]    = rx_rd_hi;
   assign rd[TX]    = tx_rd_hi;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      ptp_evstamp_classify #(
         .PTP_ETYPE  (PTP_ETYPE),
         .EVENT_PORT (EVENT_PORT),
         .EVENT_MSGS (EVENT_MSGS)
      ) u_cls (
         .hdr    (hdr[g]),
         .xcfg   (xcfg),
         .mode   (mode[g]),
         .v1_sel (v1sel[g]),
         .hit    (hit[g])
      );

      ptp_evstamp_slot #(
         .TIME_W (TIME_W)
      ) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (arm[g]),
         .sof   (sof[g]),
         .hit   (hit[g]),
         .rd_hi (rd[g]),
         .now   (time_now),
         .valid (vld[g]),
         .stamp (stamp[g])
      );
   end

   assign rx_valid    = vld[RX];
   assign rx_stamp_lo = stamp[RX][WORD_W-1:0];
   assign rx_stamp_hi = stamp[RX][TIME_W-1:WORD_W];
   assign tx_valid    = vld[TX];
   assign tx_stamp_lo = stamp[TX][WORD_W-1:0];
   assign tx_stamp_hi = stamp[TX][TIME_W-1:WORD_W];

   // R11: traffic on the transmit side never disturbs a held receive stamp
   p_rx_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_rd_hi && (tx_sof || tx_rd_hi)) |=>
      (rx_valid && $stable(rx_stamp_lo) && $stable(rx_stamp_hi)));

endmodule

// File: tb/ptp_evstamp_bench.sv
module ptp_evstamp_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = '0;
   logic        l2_chk_en = 1'b1, l4_chk_en = 1'b1, sport_chk_en = 1'b0;
   logic        rx_en = 1'b1, rx_v1_sel = 1'b0, rx_sof = 1'b0, rx_rd_hi = 1'b0;
   logic [1:0]  rx_mode = 2'd1;
   logic [15:0] rx_ethertype = '0, rx_udp_dport = '0, rx_udp_sport = '0;
   logic [7:0]  rx_ip_proto = '0;
   logic [3:0]  rx_ptp_ver = '0, rx_ptp_msg = '0;
   logic        tx_en = 1'b1, tx_v1_sel = 1'b0, tx_sof = 1'b0, tx_rd_hi = 1'b0;
   logic [1:0]  tx_mode = 2'd2;
   logic [15:0] tx_ethertype = '0, tx_udp_dport = '0, tx_udp_sport = '0;
   logic [7:0]  tx_ip_proto = '0;
   logic [3:0]  tx_ptp_ver = '0, tx_ptp_msg = '0;
   logic        rx_valid, tx_valid;
   logic [31:0] rx_stamp_lo, rx_stamp_hi, tx_stamp_lo, tx_stamp_hi;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ptp_evstamp u_ptp_evstamp (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .l2_chk_en(l2_chk_en), .l4_chk_en(l4_chk_en), .sport_chk_en(sport_chk_en),
      .rx_en(rx_en), .rx_mode(rx_mode), .rx_v1_sel(rx_v1_sel), .rx_sof(rx_sof),
      .rx_ethertype(rx_ethertype), .rx_ip_proto(rx_ip_proto),
      .rx_udp_dport(rx_udp_dport), .rx_udp_sport(rx_udp_sport),
      .rx_ptp_ver(rx_ptp_ver), .rx_ptp_msg(rx_ptp_msg), .rx_rd_hi(rx_rd_hi),
      .tx_en(tx_en), .tx_mode(tx_mode), .tx_v1_sel(tx_v1_sel), .tx_sof(tx_sof),
      .tx_ethertype(tx_ethertype), .tx_ip_proto(tx_ip_proto),
      .tx_udp_dport(tx_udp_dport), .tx_udp_sport(tx_udp_sport),
      .tx_ptp_ver(tx_ptp_ver), .tx_ptp_msg(tx_ptp_msg), .tx_rd_hi(tx_rd_hi),
      .rx_valid(rx_valid), .rx_stamp_lo(rx_stamp_lo), .rx_stamp_hi(rx_stamp_hi),
      .tx_valid(tx_valid), .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // lane 0 = receive, lane 1 = transmit; checks valid flag and stamp pair
   task automatic chk_lane(input bit tx, input string req, input logic v, input logic [63:0] st);
      if (tx) begin
         chk({req, " valid"}, {63'd0, tx_valid}, {63'd0, v});
         chk({req, " stamp"}, {tx_stamp_hi, tx_stamp_lo}, st);
      end else begin
         chk({req, " valid"}, {63'd0, rx_valid}, {63'd0, v});
         chk({req, " stamp"}, {rx_stamp_hi, rx_stamp_lo}, st);
      end
   endtask

   task automatic frame(input bit tx, input logic [15:0] et, input logic [7:0] pr,
                        input logic [15:0] dp, input logic [15:0] sp,
                        input logic [3:0] ver, input logic [3:0] msg, input logic [63:0] t);
      @(negedge clk);
      time_now = t;
      if (tx) begin
         tx_ethertype = et; tx_ip_proto = pr; tx_udp_dport = dp; tx_udp_sport = sp;
         tx_ptp_ver = ver; tx_ptp_msg = msg; tx_sof = 1'b1;
      end else begin
         rx_ethertype = et; rx_ip_proto = pr; rx_udp_dport = dp; rx_udp_sport = sp;
         rx_ptp_ver = ver; rx_ptp_msg = msg; rx_sof = 1'b1;
      end
      @(negedge clk);
      rx_sof = 1'b0;
      tx_sof = 1'b0;
      time_now = ~t;
   endtask

   task automatic read_hi(input bit tx);
      @(negedge clk);
      if (tx) tx_rd_hi = 1'b1; else rx_rd_hi = 1'b1;
      @(negedge clk);
      rx_rd_hi = 1'b0;
      tx_rd_hi = 1'b0;
   endtask

   task automatic t_reset;
      chk_lane(0, "R1 rx", 1'b0, 64'd0);
      chk_lane(1, "R1 tx", 1'b0, 64'd0);
   endtask

   task automatic t_capture_lock_release;
      rx_mode = 2'd1;
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 64'h1111_2222_3333_4444);
      chk_lane(0, "R2 l2 v2 sync", 1'b1, 64'h1111_2222_3333_4444);
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd1, 64'h5555_6666_7777_8888);
      chk_lane(0, "R3 locked", 1'b1, 64'h1111_2222_3333_4444);
      read_hi(0);
      chk_lane(0, "R4 released", 1'b0, 64'h1111_2222_3333_4444);
   endtask

   task automatic t_l2_v2;
      frame(0, 16'h0800, 8'd6, 16'd80, 16'd80, 4'd2, 4'd0, 64'hA1);
      chk_lane(0, "R6 wrong ethertype", 1'b0, 64'h1111_2222_3333_4444);
      l2_chk_en = 1'b0;
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 64'hA2);
      chk_lane(0, "R6 l2 check off", 1'b0, 64'h1111_2222_3333_4444);
      l2_chk_en = 1'b1;
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd8, 64'hA3);
      chk_lane(0, "R9 general msg", 1'b0, 64'h1111_2222_3333_4444);
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd4, 64'hA4);
      chk_lane(0, "R9 msg 4", 1'b0, 64'h1111_2222_3333_4444);
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd3, 64'hA5);
      chk_lane(0, "R9 msg 3", 1'b1, 64'hA5);
      read_hi(0);
   endtask

   task automatic t_l4;
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd5000, 4'd2, 4'd1, 64'hB1);
      chk_lane(0, "R7 udp 319", 1'b1, 64'hB1);
      read_hi(0);
      frame(0, 16'h0800, 8'd17, 16'd320, 16'd5000, 4'd2, 4'd1, 64'hB2);
      chk_lane(0, "R7 port 320", 1'b0, 64'hB1);
      frame(0, 16'h0800, 8'd6, 16'd319, 16'd5000, 4'd2, 4'd1, 64'hB3);
      chk_lane(0, "R7 tcp", 1'b0, 64'hB1);
      sport_chk_en = 1'b1;
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd5000, 4'd2, 4'd1, 64'hB4);
      chk_lane(0, "R7 sport mismatch", 1'b0, 64'hB1);
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd319, 4'd2, 4'd1, 64'hB5);
      chk_lane(0, "R7 sport match", 1'b1, 64'hB5);
      read_hi(0);
      sport_chk_en = 1'b0;
   endtask

   task automatic t_v1;
      rx_mode = 2'd0;
      rx_v1_sel = 1'b1;
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd1, 4'd1, 4'd1, 64'hC1);
      chk_lane(0, "R8 v1 delay_req", 1'b1, 64'hC1);
      read_hi(0);
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd1, 4'd1, 4'd0, 64'hC2);
      chk_lane(0, "R8 v1 sync not selected", 1'b0, 64'hC1);
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd1, 4'd2, 4'd1, 64'hC3);
      chk_lane(0, "R8 version 2 rejected", 1'b0, 64'hC1);
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd1, 4'd1, 64'hC4);
      chk_lane(0, "R8 l2 rejected", 1'b0, 64'hC1);
      rx_v1_sel = 1'b0;
      frame(0, 16'h0800, 8'd17, 16'd319, 16'd1, 4'd1, 4'd0, 64'hC5);
      chk_lane(0, "R8 v1 sync", 1'b1, 64'hC5);
      read_hi(0);
   endtask

   task automatic t_all_none;
      rx_mode = 2'd2;
      frame(0, 16'h1234, 8'd99, 16'd7, 16'd7, 4'd9, 4'd15, 64'hD1);
      chk_lane(0, "R10 all mode", 1'b1, 64'hD1);
      read_hi(0);
      rx_mode = 2'd3;
      frame(0, 16'h88F7, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0, 64'hD2);
      chk_lane(0, "R10 none mode", 1'b0, 64'hD1);
      rx_mode = 2'd1;
   endtask

   task automatic t_enable;
      rx_en = 1'b0;
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 64'hE1);
      chk_lane(0, "R5 disabled", 1'b0, 64'hD1);
      rx_en = 1'b1;
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 64'hE2);
      chk_lane(0, "R5 enabled", 1'b1, 64'hE2);
      rx_en = 1'b0;
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 64'hE3);
      chk_lane(0, "R5 pending kept", 1'b1, 64'hE2);
      read_hi(0);
      chk_lane(0, "R5 pending read", 1'b0, 64'hE2);
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 64'hE4);
      chk_lane(0, "R5 no new capture", 1'b0, 64'hE2);
      rx_en = 1'b1;
   endtask

   task automatic t_lanes;
      frame(1, 16'h0000, 8'd0, 16'd0, 16'd0, 4'd0, 4'd0, 64'hF1);
      chk_lane(1, "R11 tx capture", 1'b1, 64'hF1);
      chk_lane(0, "R11 rx untouched", 1'b0, 64'hE2);
      frame(0, 16'h88F7, 8'd0, 16'd0, 16'd0, 4'd2, 4'd2, 64'hF2);
      chk_lane(0, "R11 rx capture", 1'b1, 64'hF2);
      chk_lane(1, "R11 tx kept", 1'b1, 64'hF1);
      read_hi(1);
      chk_lane(1, "R11 tx read", 1'b0, 64'hF1);
      chk_lane(0, "R11 rx still held", 1'b1, 64'hF2);
      read_hi(0);
      chk_lane(0, "R11 rx read", 1'b0, 64'hF2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_capture_lock_release;
      t_l2_v2;
      t_l4;
      t_v1;
      t_all_none;
      t_enable;
      t_lanes;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule